// File: doc/BRIEF.md
# Contact Card Slot Power Sequencer

This block brings a contact smart card slot up and down in a fixed, timed order. Host software writes a start/stop bit in a control port. On start, the block turns the card supply on and waits a span of internal oscillator ticks. It then checks that the supply is good and switches the card I/O line to receive. After a short further gap it ungates the card clock. It raises card reset only after a long run of card clock cycles has passed.

Two events bring the slot down: a stop command and a thermal alarm. A supply that is not good when the first delay ends also brings it down. Deactivation drops card reset, then the clock, then I/O, then the supply, with equal oscillator-timed gaps between the steps.

A power-down request only takes hold while the slot is idle. After power-down is released, and also after reset, the block waits out a settling period. During that period it refuses to start and holds its active-low interrupt low. Faults are latched in a status byte, which software reads through a simple read port. Reading the byte clears the latched faults.

Top module: `sc_act_seq`

## Requirements
- R1: A write with `wr_data[0]`=1 starts activation only when the block is idle, the card is present, the block is not settling, power-down is not in effect and no thermal alarm is raised; otherwise it is ignored. A write with `wr_data[0]`=0 during any powered phase starts deactivation.
- R2: The outputs nest at all times: `rst_card` high implies `clk_en`, `clk_en` implies `io_en`, and `io_en` implies `vcc_en`. On activation they rise in the order supply, I/O, clock, reset.
- R3: `io_en` rises exactly SUP_TICKS oscillator ticks after `vcc_en` rises.
- R4: `clk_en` rises exactly CLK_DLY_TICKS oscillator ticks after `io_en` rises.
- R5: `rst_card` rises exactly RST_CYCLES card clock ticks after `clk_en` rises.
- R6: If `vcc_ok` is low when the supply delay ends, activation is aborted, deactivation follows, and status bit 3 (supply fault) is latched.
- R7: `over_temp` during any powered phase drops `rst_card` on the next clock edge and starts deactivation. `over_temp` always latches status bit 4 (thermal fault).
- R8: During deactivation, reset falls first. The clock, I/O and supply then fall in that order, each DEACT_TICKS/4 oscillator ticks after the previous step. The block is idle again after a further DEACT_TICKS/4 ticks.
- R9: `pwrdn_req` has no effect while a session is powered. It takes effect in the idle state and is then shown in status bit 5.
- R10: After reset, and after an in-effect power-down is released, the block settles for SETTLE_TICKS oscillator ticks. While settling, `irq_n` is low, status bit 6 is set and start commands are refused.
- R11: A read returns a status byte on the next cycle, laid out as follows. Bit 0 is card present, bit 1 is supply valid, bit 2 is supply enabled, bit 3 is the supply fault, bit 4 is the thermal fault, bit 5 is power-down in effect, bit 6 is settling, and bit 7 is zero. The read clears bits 3 and 4. `irq_n` is low while either bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per internal oscillator period |
| cclk_tick | input | 1 | One-cycle pulse per card clock period |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | DW | Control write data, bit 0 is start/stop |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | DW | Status byte, valid the cycle after `rd_en` |
| card_present | input | 1 | Card detected in slot |
| vcc_ok | input | 1 | Card supply within range |
| over_temp | input | 1 | Thermal alarm |
| pwrdn_req | input | 1 | Power-down request |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card I/O in receive mode |
| clk_en | output | 1 | Card clock gate |
| rst_card | output | 1 | Card reset |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A table drives four start attempts, one for each combination that matters. A present card with a good supply must reach the reset-high stage. A present card with a bad supply must abort and latch the supply fault. An absent card must leave the slot unpowered. A repeated good row shows that the previous read cleared the fault. Edge-to-edge cycle stamps taken at the outputs separate the supply, I/O, clock and reset delays from one another during activation, and the three equal gaps during deactivation. Directed runs cover the following:
- a thermal alarm during a live session;
- a power-down raised mid-session and then released;
- start attempts refused during settling.

// File: rtl/sc_act_pkg.sv
package sc_act_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SUPPLY = 3'd1,
    ST_IOWAIT = 3'd2,
    ST_CLKRUN = 3'd3,
    ST_ACTIVE = 3'd4,
    ST_DEACT  = 3'd5
  } seq_state_e;

  localparam int SB_PRESENT  = 0;
  localparam int SB_VCCOK    = 1;
  localparam int SB_SESSION  = 2;
  localparam int SB_SUPFAULT = 3;
  localparam int SB_THERMAL  = 4;
  localparam int SB_PWRDN    = 5;
  localparam int SB_SETTLE   = 6;

  localparam int DEACT_PHASES = 4;

endpackage

// File: rtl/sc_tick_cnt.sv
module sc_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q;

  assign hit = en && (cnt_q == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/sc_status.sv
module sc_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          card_present,
  input  logic          vcc_ok,
  input  logic          session,
  input  logic          sup_fault_set,
  input  logic          thermal_set,
  input  logic          pwrdn,
  input  logic          settling,
  output logic [DW-1:0] rd_data,
  output logic          irq_n
);
  import sc_act_pkg::*;

  logic sup_fault_q;
  logic thermal_q;
  logic [DW-1:0] status;

  always_comb begin
    status = '0;
    status[SB_PRESENT]  = card_present;
    status[SB_VCCOK]    = vcc_ok;
    status[SB_SESSION]  = session;
    status[SB_SUPFAULT] = sup_fault_q;
    status[SB_THERMAL]  = thermal_q;
    status[SB_PWRDN]    = pwrdn;
    status[SB_SETTLE]   = settling;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_fault_q <= 1'b0;
      thermal_q   <= 1'b0;
      rd_data     <= '0;
      irq_n       <= 1'b0;
    end else begin
      if (rd_en) begin
        rd_data <= status;
      end
      sup_fault_q <= sup_fault_set || (sup_fault_q && !rd_en);
      thermal_q   <= thermal_set || (thermal_q && !rd_en);
      irq_n       <= !(settling || sup_fault_q || thermal_q);
    end
  end

endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq #(
  parameter int DW            = 8,
  parameter int SUP_TICKS     = 765,
  parameter int CLK_DLY_TICKS = 1,
  parameter int RST_CYCLES    = 42000,
  parameter int DEACT_TICKS   = 150,
  parameter int SETTLE_TICKS  = 15000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_tick,
  input  logic          cclk_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          card_present,
  input  logic          vcc_ok,
  input  logic          over_temp,
  input  logic          pwrdn_req,
  output logic          vcc_en,
  output logic          io_en,
  output logic          clk_en,
  output logic          rst_card,
  output logic          irq_n
);
  import sc_act_pkg::*;

  localparam int STEP_TICKS = DEACT_TICKS / DEACT_PHASES;
  localparam int OSC_W      = $clog2(SUP_TICKS + CLK_DLY_TICKS + STEP_TICKS + 1);
  localparam int CC_W       = $clog2(RST_CYCLES + 1);
  localparam int ST_W       = $clog2(SETTLE_TICKS + 1);
  localparam int PH_W       = $clog2(DEACT_PHASES);

  seq_state_e state_q, state_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic [OSC_W-1:0] osc_limit;
  logic osc_hit, cc_hit, settle_hit;
  logic step_clr;
  logic pd_q, pd_fall, settling_q;
  logic start_ok, stop_cmd, powered, sup_fault;

  assign powered  = (state_q == ST_SUPPLY) || (state_q == ST_IOWAIT) ||
                    (state_q == ST_CLKRUN) || (state_q == ST_ACTIVE);
  assign start_ok = wr_en && wr_data[0] && card_present && !settling_q &&
                    !pd_q && !over_temp;
  assign stop_cmd = wr_en && !wr_data[0];
  assign step_clr = (state_d != state_q) || (phase_d != phase_q);
  assign pd_fall  = pd_q && !pwrdn_req && (state_q == ST_IDLE);

  always_comb begin
    case (state_q)
      ST_SUPPLY: osc_limit = OSC_W'(SUP_TICKS);
      ST_IOWAIT: osc_limit = OSC_W'(CLK_DLY_TICKS);
      default:   osc_limit = OSC_W'(STEP_TICKS);
    endcase
  end

  sc_tick_cnt #(.W(OSC_W)) u_osc_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (step_clr),
    .en    (osc_tick),
    .limit (osc_limit),
    .hit   (osc_hit)
  );

  sc_tick_cnt #(.W(CC_W)) u_cclk_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (step_clr),
    .en    (cclk_tick && (state_q == ST_CLKRUN)),
    .limit (CC_W'(RST_CYCLES)),
    .hit   (cc_hit)
  );

  sc_tick_cnt #(.W(ST_W)) u_settle_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (pd_fall),
    .en    (osc_tick && settling_q),
    .limit (ST_W'(SETTLE_TICKS)),
    .hit   (settle_hit)
  );

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    sup_fault = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) state_d = ST_SUPPLY;
      end
      ST_SUPPLY: begin
        if (osc_hit) begin
          if (vcc_ok) begin
            state_d = ST_IOWAIT;
          end else begin
            state_d   = ST_DEACT;
            sup_fault = 1'b1;
          end
        end
      end
      ST_IOWAIT: begin
        if (osc_hit) state_d = ST_CLKRUN;
      end
      ST_CLKRUN: begin
        if (cc_hit) state_d = ST_ACTIVE;
      end
      ST_DEACT: begin
        if (osc_hit) begin
          if (phase_q == PH_W'(DEACT_PHASES - 1)) begin
            state_d = ST_IDLE;
            phase_d = '0;
          end else begin
            phase_d = phase_q + PH_W'(1);
          end
        end
      end
      default: state_d = state_q;
    endcase
    if (powered && (over_temp || stop_cmd)) begin
      state_d = ST_DEACT;
      phase_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcc_en   <= 1'b0;
      io_en    <= 1'b0;
      clk_en   <= 1'b0;
      rst_card <= 1'b0;
    end else begin
      case (state_d)
        ST_SUPPLY: begin
          vcc_en <= 1'b1; io_en <= 1'b0; clk_en <= 1'b0; rst_card <= 1'b0;
        end
        ST_IOWAIT: begin
          vcc_en <= 1'b1; io_en <= 1'b1; clk_en <= 1'b0; rst_card <= 1'b0;
        end
        ST_CLKRUN: begin
          vcc_en <= 1'b1; io_en <= 1'b1; clk_en <= 1'b1; rst_card <= 1'b0;
        end
        ST_ACTIVE: begin
          vcc_en <= 1'b1; io_en <= 1'b1; clk_en <= 1'b1; rst_card <= 1'b1;
        end
        ST_DEACT: begin
          rst_card <= 1'b0;
          clk_en   <= clk_en && (phase_d < PH_W'(1));
          io_en    <= io_en  && (phase_d < PH_W'(2));
          vcc_en   <= vcc_en && (phase_d < PH_W'(3));
        end
        default: begin
          vcc_en <= 1'b0; io_en <= 1'b0; clk_en <= 1'b0; rst_card <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q       <= 1'b0;
      settling_q <= 1'b1;
    end else begin
      if (state_q == ST_IDLE) pd_q <= pwrdn_req;
      if (pd_fall) begin
        settling_q <= 1'b1;
      end else if (settle_hit) begin
        settling_q <= 1'b0;
      end
    end
  end

  sc_status #(.DW(DW)) u_status (
    .clk           (clk),
    .rst           (rst),
    .rd_en         (rd_en),
    .card_present  (card_present),
    .vcc_ok        (vcc_ok),
    .session       (vcc_en),
    .sup_fault_set (sup_fault),
    .thermal_set   (over_temp),
    .pwrdn         (pd_q),
    .settling      (settling_q),
    .rd_data       (rd_data),
    .irq_n         (irq_n)
  );

endmodule

// File: rtl/sc_act_seq_chk.sv
module sc_act_seq_chk (
  input logic clk,
  input logic rst,
  input logic over_temp,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic rst_card,
  input logic irq_n,
  input logic pd_q,
  input logic settling_q
);

  a_r2_rst_needs_clk: assert property (@(posedge clk) disable iff (rst)
    rst_card |-> clk_en);

  a_r2_clk_needs_io: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> io_en);

  a_r2_io_needs_vcc: assert property (@(posedge clk) disable iff (rst)
    io_en |-> vcc_en);

  a_r7_thermal_drops_rst: assert property (@(posedge clk) disable iff (rst)
    (over_temp && rst_card) |=> !rst_card);

  a_r8_vcc_falls_last: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en) |-> !$past(io_en));

  a_r9_no_start_in_pwrdn: assert property (@(posedge clk) disable iff (rst)
    $rose(vcc_en) |-> (!$past(pd_q) && !$past(settling_q)));

  a_r10_irq_low_settling: assert property (@(posedge clk) disable iff (rst)
    settling_q |=> !irq_n);

endmodule

bind sc_act_seq sc_act_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .over_temp  (over_temp),
  .vcc_en     (vcc_en),
  .io_en      (io_en),
  .clk_en     (clk_en),
  .rst_card   (rst_card),
  .irq_n      (irq_n),
  .pd_q       (pd_q),
  .settling_q (settling_q)
);

// File: tb/sc_act_seq_bench.sv
`timescale 1ns/1ps
module sc_act_seq_bench;

  localparam int DW     = 8;
  localparam int SUP    = 20;
  localparam int CD     = 3;
  localparam int RC     = 60;
  localparam int DEACT  = 40;
  localparam int STEP   = DEACT / 4;
  localparam int SETTLE = 50;
  localparam int ACT_WAIT = SUP + CD + RC + 5;

  // {card_present, vcc_ok, expect_reset_high, expect_supply_fault}
  localparam logic [3:0] VEC [4] = '{4'b1110, 4'b1001, 4'b0100, 4'b1110};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b1, cclk_tick = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic card_present = 1'b1, vcc_ok = 1'b1, over_temp = 1'b0, pwrdn_req = 1'b0;
  logic vcc_en, io_en, clk_en, rst_card, irq_n;

  int checks = 0, errors = 0;
  bit done = 0;
  int cyc = 0;
  int t_vcc_r, t_io_r, t_clk_r, t_rst_r, t_rst_f, t_clk_f, t_io_f, t_vcc_f;
  logic p_vcc = 0, p_io = 0, p_clk = 0, p_rst = 0;

  always #2 clk = ~clk;

  sc_act_seq #(
    .DW(DW), .SUP_TICKS(SUP), .CLK_DLY_TICKS(CD), .RST_CYCLES(RC),
    .DEACT_TICKS(DEACT), .SETTLE_TICKS(SETTLE)
  ) u_sc_act_seq (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cclk_tick(cclk_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .card_present(card_present), .vcc_ok(vcc_ok), .over_temp(over_temp),
    .pwrdn_req(pwrdn_req), .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en),
    .rst_card(rst_card), .irq_n(irq_n)
  );

  always @(negedge clk) begin
    cyc++;
    if (vcc_en && !p_vcc) t_vcc_r = cyc;
    if (io_en && !p_io) t_io_r = cyc;
    if (clk_en && !p_clk) t_clk_r = cyc;
    if (rst_card && !p_rst) t_rst_r = cyc;
    if (!vcc_en && p_vcc) t_vcc_f = cyc;
    if (!io_en && p_io) t_io_f = cyc;
    if (!clk_en && p_clk) t_clk_f = cyc;
    if (!rst_card && p_rst) t_rst_f = cyc;
    p_vcc = vcc_en; p_io = io_en; p_clk = clk_en; p_rst = rst_card;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(logic b);
    @(negedge clk); wr_en = 1'b1; wr_data = {{(DW-1){1'b0}}, b};
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [DW-1:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] s;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    // Reset state and settling (R10)
    chk("R2 reset vcc_en", vcc_en, 0);
    chk("R2 reset rst_card", rst_card, 0);
    chk("R10 irq_n low while settling", irq_n, 0);
    cmd(1'b1);
    wait_cyc(3);
    chk("R10 start refused while settling", vcc_en, 0);
    rd(s);
    chk("R11 settling bit6", s[6], 1);
    wait_cyc(SETTLE + 5);
    chk("R10 irq_n high after settling", irq_n, 1);

    // Table of start attempts (R1, R6, R11)
    foreach (VEC[i]) begin
      card_present = VEC[i][3];
      vcc_ok = VEC[i][2];
      cmd(1'b1);
      wait_cyc(ACT_WAIT);
      chk($sformatf("R1 row %0d reset level", i), rst_card, VEC[i][1]);
      rd(s);
      chk($sformatf("R6 row %0d supply fault bit3", i), s[3], VEC[i][0]);
      chk($sformatf("R11 row %0d present bit0", i), s[0], VEC[i][3]);
      cmd(1'b0);
      wait_cyc(DEACT + 5);
      chk($sformatf("R1 row %0d supply off after stop", i), vcc_en, 0);
    end
    card_present = 1'b1; vcc_ok = 1'b1;
    rd(s);
    chk("R11 fault cleared by read", s[3], 0);

    // Activation timing stamps (R2..R5), deactivation spacing (R8)
    cmd(1'b1);
    wait_cyc(ACT_WAIT);
    chk("R3 supply to io", t_io_r - t_vcc_r, SUP);
    chk("R4 io to clock", t_clk_r - t_io_r, CD);
    chk("R5 clock to reset", t_rst_r - t_clk_r, RC);
    cmd(1'b0);
    wait_cyc(DEACT + 5);
    chk("R8 reset to clock off", t_clk_f - t_rst_f, STEP);
    chk("R8 clock to io off", t_io_f - t_clk_f, STEP);
    chk("R8 io to supply off", t_vcc_f - t_io_f, STEP);

    // Thermal alarm (R7)
    cmd(1'b1);
    wait_cyc(ACT_WAIT);
    chk("R7 session up", rst_card, 1);
    @(negedge clk); over_temp = 1'b1;
    @(negedge clk); over_temp = 1'b0;
    chk("R7 reset dropped next edge", rst_card, 0);
    wait_cyc(3);
    chk("R11 irq_n low on fault", irq_n, 0);
    rd(s);
    chk("R7 thermal bit4", s[4], 1);
    wait_cyc(DEACT + 5);
    chk("R7 supply off after thermal", vcc_en, 0);
    chk("R11 irq_n high after read", irq_n, 1);

    // Power-down (R9, R10)
    cmd(1'b1);
    wait_cyc(ACT_WAIT);
    pwrdn_req = 1'b1;
    wait_cyc(10);
    chk("R9 pwrdn ignored in session", rst_card, 1);
    rd(s);
    chk("R9 pwrdn bit5 clear in session", s[5], 0);
    cmd(1'b0);
    wait_cyc(DEACT + 5);
    rd(s);
    chk("R9 pwrdn bit5 set when idle", s[5], 1);
    cmd(1'b1);
    wait_cyc(3);
    chk("R9 start refused in power-down", vcc_en, 0);
    pwrdn_req = 1'b0;
    wait_cyc(3);
    chk("R10 irq_n low after release", irq_n, 0);
    cmd(1'b1);
    wait_cyc(3);
    chk("R10 start refused after release", vcc_en, 0);
    wait_cyc(SETTLE + 5);
    chk("R10 irq_n high after settle", irq_n, 1);
    cmd(1'b1);
    wait_cyc(2);
    chk("R1 start accepted after settle", vcc_en, 1);
    cmd(1'b0);
    wait_cyc(DEACT + 5);
    chk("R1 idle at end", vcc_en, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule